// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the control front end of a multi-channel clock divider and distributor. A host programs it over three wires: a serial clock, a serial data line and a latch enable. The three lines are resynchronized into the system clock domain, where a state machine shifts one data bit per serial clock rise into a 32-bit word. When latch enable rises, the word is decoded and committed to one register of the bank.

The bank holds one register per output channel and two global registers. The channel registers hold the channel's path mode, enable, divider code and delay code. One global register holds the global output enable, the input select and the power-down bit. The other holds the output boost bit. All decoded fields appear as flat output buses for the channel datapaths. A command word aimed at register 0 with its top bit set restores every register to its power-on value. Words aimed at any address the bank does not hold are dropped.

The loader state machine has four states. `ST_SHIFT` takes in bits while latch enable is low. `ST_WRITE` commits a word to a held register. `ST_SOFTRST` restores all defaults. `ST_HOLD` waits for latch enable to fall. On a latch rise, `ST_SHIFT` moves to one of three states. It goes to `ST_SOFTRST` when the address is 0 and bit 31 is set. It goes to `ST_WRITE` when the address is held. For any other address it goes straight to `ST_HOLD`, and the word is dropped. `ST_WRITE` and `ST_SOFTRST` each last one cycle and then move to `ST_HOLD`. `ST_HOLD` returns to `ST_SHIFT` once the synchronized latch level is low.

Top module: `cfg_serial_bank`

## Requirements
- R1: Each synchronized rising edge of the serial clock, taken while latch enable is low, shifts the data line into the low end of a 32-bit word. The first bit sent therefore ends in bit 31, and only the last 32 bits sent before the latch count.
- R2: A rising edge of latch enable commits the word. Bits 3:0 are the address. For addresses 0 to NCH-1, the addressed channel takes its mode from bits 18:17, its enable from bit 16, its divider code from bits 15:8 and its delay code from bits 7:4. All other bits are ignored.
- R3: Address 14 is the global register. Bit 27 is the global output enable, bit 26 is power-down and bit 29 is the input select (0 picks the second clock input, 1 the first).
- R4: Address 9 holds the boost bit in word bit 16.
- R5: A word sent to any other address (8, 10 to 13, 15) changes no output.
- R6: A word with address 0 and bit 31 set restores every register to its default and writes none of its other bits. Bit 31 is not kept, so a later word to address 0 with bit 31 clear is an ordinary channel write. Bit 31 has no reset meaning for any other address.
- R7: The asynchronous reset gives these defaults. Every channel has mode 0 (bypass), enable 0, divider code 1 (ratio 2) and delay code 0. Global enable is 1, input select 0, power-down 0 and boost 0.
- R8: Serial clock edges while latch enable is high are not shifted into the word.
- R9: A channel write changes only the addressed channel's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_sclk | input | 1 | Serial clock, asynchronous |
| cfg_sdat | input | 1 | Serial data, asynchronous |
| cfg_latch | input | 1 | Latch enable, asynchronous |
| ch_mode_o | output | 2*NCH | Path mode per channel, channel i at [2i+1:2i] |
| ch_en_o | output | NCH | Channel enable per channel |
| ch_div_o | output | 8*NCH | Divider code per channel (ratio = 2 x code) |
| ch_dly_o | output | 4*NCH | Delay code per channel, 150 ps per step |
| glb_en_o | output | 1 | Global output enable |
| in_sel_o | output | 1 | Input select, 0 = second input |
| boost_o | output | 1 | Output boost |
| pwr_down_o | output | 1 | Device power-down |

## Verification
The assertions check four properties on every cycle. A channel or global field changes only on a commit or soft-reset action. A non-addressed channel stays put during a write. The word cannot move while latch enable is high. A soft reset always lands the bank on its defaults one cycle later. Several behaviours need the bench's scenarios to show them: bit order and field placement, global and boost bit positions, dropping of unheld addresses, the top bit acting as reset only at address 0, and the 30-bit short-word case that exposes shifting during latch-high.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 4;

    // channel register field positions in the command word
    localparam int MODE_LO  = 17;
    localparam int EN_BIT   = 16;
    localparam int DIV_LO   = 8;
    localparam int DLY_LO   = 4;
    localparam int MODE_W   = 2;
    localparam int DIV_W    = 8;
    localparam int DLY_W    = 4;

    // soft reset and global registers
    localparam int SRST_BIT   = 31;
    localparam int GLB_ADDR   = 14;
    localparam int BOOST_ADDR = 9;
    localparam int BOOST_BIT  = 16;
    localparam int GEN_BIT    = 27;
    localparam int PD_BIT     = 26;
    localparam int INSEL_BIT  = 29;

    typedef enum logic [1:0] {
        ST_SHIFT   = 2'd0,
        ST_WRITE   = 2'd1,
        ST_SOFTRST = 2'd2,
        ST_HOLD    = 2'd3
    } ld_state_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [DLY_W-1:0]  dly;
    } ch_cfg_t;

    localparam ch_cfg_t CH_DEFAULT = '{mode: '0, en: 1'b0, div: 8'd1, dly: '0};

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign level_o = stg[STAGES-1];
    assign rise_o  = stg[STAGES-1] & ~prev_q;

endmodule

// File: rtl/cfgs_loader.sv
module cfgs_loader
    import cfgs_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              dat_lvl,
    input  logic              lat_lvl,
    input  logic              lat_rise,
    output logic [WORD_W-1:0] word_o,
    output logic              wr_o,
    output logic              srst_o
);

    ld_state_t         state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic              addr_held;

    assign addr      = shreg[ADDR_W-1:0];
    assign addr_held = (int'(addr) < NCH) || (int'(addr) == GLB_ADDR)
                     || (int'(addr) == BOOST_ADDR);

    // word assembly: only in ST_SHIFT with latch low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (state == ST_SHIFT && !lat_lvl && sclk_rise)
            shreg <= {shreg[WORD_W-2:0], dat_lvl};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SHIFT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT: begin
                if (lat_rise) begin
                    if (addr == '0 && shreg[SRST_BIT]) state_nx = ST_SOFTRST;
                    else if (addr_held)                 state_nx = ST_WRITE;
                    else                                state_nx = ST_HOLD;
                end
            end
            ST_WRITE:   state_nx = ST_HOLD;
            ST_SOFTRST: state_nx = ST_HOLD;
            ST_HOLD:    if (!lat_lvl) state_nx = ST_SHIFT;
            default:    state_nx = ST_SHIFT;
        endcase
    end

    // outputs
    always_comb begin
        wr_o   = 1'b0;
        srst_o = 1'b0;
        unique case (state)
            ST_WRITE:   wr_o   = 1'b1;
            ST_SOFTRST: srst_o = 1'b1;
            default: ;
        endcase
    end

    assign word_o = shreg;

    // R6: commit and soft reset never coincide
    a_r6_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, srst_o}));

    // R6: soft reset only from address 0 with the top bit set
    a_r6_srst_source: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |-> (word_o[ADDR_W-1:0] == '0 && word_o[SRST_BIT]));

    // R8: word frozen while latch enable is high
    a_r8_frozen_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
        lat_lvl |=> $stable(word_o));

    // R2: a commit follows a latch rise by one cycle
    a_r2_commit_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $past(lat_rise));

endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
    import cfgs_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              srst_i,
    input  logic [WORD_W-1:0] word_i,
    output ch_cfg_t           ch_q [NCH],
    output logic              glb_en_q,
    output logic              in_sel_q,
    output logic              boost_q,
    output logic              pwr_down_q
);

    logic [ADDR_W-1:0] addr;
    ch_cfg_t           wr_fields;
    logic [NCH-1:0]    en_vec;
    logic              unused_bits;

    assign addr      = word_i[ADDR_W-1:0];
    assign wr_fields = '{mode: word_i[MODE_LO +: MODE_W],
                         en:   word_i[EN_BIT],
                         div:  word_i[DIV_LO +: DIV_W],
                         dly:  word_i[DLY_LO +: DLY_W]};
    assign unused_bits = ^{word_i[31:30], word_i[28], word_i[25:19]};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ch_q[i] <= CH_DEFAULT;
            else if (srst_i)
                ch_q[i] <= CH_DEFAULT;
            else if (wr_i && addr == ADDR_W'(i))
                ch_q[i] <= wr_fields;
        end
        assign en_vec[i] = ch_q[i].en;

        // R9: other channels hold during a write
        a_r9_neighbour_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr != ADDR_W'(i)) |=> $stable(ch_q[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en_q   <= 1'b1;
            in_sel_q   <= 1'b0;
            pwr_down_q <= 1'b0;
            boost_q    <= 1'b0;
        end else if (srst_i) begin
            glb_en_q   <= 1'b1;
            in_sel_q   <= 1'b0;
            pwr_down_q <= 1'b0;
            boost_q    <= 1'b0;
        end else if (wr_i) begin
            if (int'(addr) == GLB_ADDR) begin
                glb_en_q   <= word_i[GEN_BIT];
                in_sel_q   <= word_i[INSEL_BIT];
                pwr_down_q <= word_i[PD_BIT];
            end
            if (int'(addr) == BOOST_ADDR)
                boost_q <= word_i[BOOST_BIT];
        end
    end

    // R6: soft reset lands on defaults
    a_r6_defaults_after_srst: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (en_vec == '0 && glb_en_q && !in_sel_q && !pwr_down_q && !boost_q));

    // R5: without an action nothing moves
    a_r5_quiet_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !srst_i) |=> ($stable(en_vec) && $stable(glb_en_q) && $stable(in_sel_q)
                                && $stable(pwr_down_q) && $stable(boost_q)));

endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
    import cfgs_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sclk,
    input  logic               cfg_sdat,
    input  logic               cfg_latch,
    output logic [2*NCH-1:0]   ch_mode_o,
    output logic [NCH-1:0]     ch_en_o,
    output logic [8*NCH-1:0]   ch_div_o,
    output logic [4*NCH-1:0]   ch_dly_o,
    output logic               glb_en_o,
    output logic               in_sel_o,
    output logic               boost_o,
    output logic               pwr_down_o
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] lvl, rise;
    logic [WORD_W-1:0] word;
    logic              wr, srst;
    ch_cfg_t           ch_q [NCH];

    cfgs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cfg_latch, cfg_sdat, cfg_sclk}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    cfgs_loader #(.NCH(NCH)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (rise[0]),
        .dat_lvl   (lvl[1]),
        .lat_lvl   (lvl[2]),
        .lat_rise  (rise[2]),
        .word_o    (word),
        .wr_o      (wr),
        .srst_o    (srst)
    );

    cfgs_regbank #(.NCH(NCH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .srst_i     (srst),
        .word_i     (word),
        .ch_q       (ch_q),
        .glb_en_q   (glb_en_o),
        .in_sel_q   (in_sel_o),
        .boost_q    (boost_o),
        .pwr_down_q (pwr_down_o)
    );

    logic unused_rise;
    assign unused_rise = rise[1];

    for (genvar i = 0; i < NCH; i++) begin : g_flat
        assign ch_mode_o[2*i +: 2] = ch_q[i].mode;
        assign ch_en_o[i]          = ch_q[i].en;
        assign ch_div_o[8*i +: 8]  = ch_q[i].div;
        assign ch_dly_o[4*i +: 4]  = ch_q[i].dly;
    end

endmodule

// File: tb/cfg_serial_bank_test.sv
module cfg_serial_bank_test;

    localparam int NCH = 8;
    localparam int SW  = 2*NCH + NCH + 8*NCH + 4*NCH + 4;
    localparam int NV  = 13;

    // word table and the requirement each entry exercises
    localparam logic [31:0] VEC [NV] = '{
        32'h0005_7FA3,  // R2 channel 3 fields
        32'h0007_FFF0,  // R1 MSB-first, channel 0 all ones
        32'h0002_0257,  // R9 channel 7 only
        32'hFFF9_5537,  // R6 top bit at address 7 is no reset
        32'h2400_000E,  // R3 global register
        32'h0001_0009,  // R4 boost
        32'hFFFF_FFF8,  // R5 address 8 dropped
        32'hFFFF_FFFB,  // R5 address 11 dropped
        32'hFFFF_FFFF,  // R5 address 15 dropped
        32'h0800_000E,  // R3 global enable back on
        32'hFFFF_FFF0,  // R6 soft reset, other bits ignored
        32'h7FFF_FFF0,  // R6 address 0 ordinary write afterwards
        32'h0003_1265   // R9 channel 5
    };
    localparam int VREQ [NV] = '{2, 1, 9, 6, 3, 4, 5, 5, 5, 3, 6, 6, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sclk = 1'b0, cfg_sdat = 1'b0, cfg_latch = 1'b0;
    logic [2*NCH-1:0] ch_mode_o;
    logic [NCH-1:0]   ch_en_o;
    logic [8*NCH-1:0] ch_div_o;
    logic [4*NCH-1:0] ch_dly_o;
    logic glb_en_o, in_sel_o, boost_o, pwr_down_o;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model
    logic [1:0] m_mode [NCH];
    logic       m_en   [NCH];
    logic [7:0] m_div  [NCH];
    logic [3:0] m_dly  [NCH];
    logic m_gen, m_insel, m_boost, m_pd;

    always #2.5 clk = ~clk;

    cfg_serial_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdat(cfg_sdat),
        .cfg_latch(cfg_latch), .ch_mode_o(ch_mode_o), .ch_en_o(ch_en_o),
        .ch_div_o(ch_div_o), .ch_dly_o(ch_dly_o), .glb_en_o(glb_en_o),
        .in_sel_o(in_sel_o), .boost_o(boost_o), .pwr_down_o(pwr_down_o)
    );

    task automatic model_defaults();
        for (int i = 0; i < NCH; i++) begin
            m_mode[i] = 2'd0; m_en[i] = 1'b0; m_div[i] = 8'd1; m_dly[i] = 4'd0;
        end
        m_gen = 1'b1; m_insel = 1'b0; m_boost = 1'b0; m_pd = 1'b0;
    endtask

    task automatic model_apply(input logic [31:0] w);
        int a;
        a = int'(w[3:0]);
        if (a == 0 && w[31]) model_defaults();
        else if (a < NCH) begin
            m_mode[a] = w[18:17]; m_en[a] = w[16]; m_div[a] = w[15:8]; m_dly[a] = w[7:4];
        end else if (a == 14) begin
            m_gen = w[27]; m_pd = w[26]; m_insel = w[29];
        end else if (a == 9) m_boost = w[16];
    endtask

    function automatic logic [SW-1:0] expected();
        logic [2*NCH-1:0] mo; logic [NCH-1:0] en; logic [8*NCH-1:0] dv; logic [4*NCH-1:0] dl;
        for (int i = 0; i < NCH; i++) begin
            mo[2*i +: 2] = m_mode[i]; en[i] = m_en[i];
            dv[8*i +: 8] = m_div[i];  dl[4*i +: 4] = m_dly[i];
        end
        return {mo, en, dv, dl, m_gen, m_insel, m_boost, m_pd};
    endfunction

    task automatic check(input string req);
        logic [SW-1:0] act, exp;
        act = {ch_mode_o, ch_en_o, ch_div_o, ch_dly_o, glb_en_o, in_sel_o, boost_o, pwr_down_o};
        exp = expected();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            cfg_sdat = w[i];
            wait_clk(3);
            cfg_sclk = 1'b1;
            wait_clk(3);
            cfg_sclk = 1'b0;
            wait_clk(1);
        end
    endtask

    // latch pulse; extra serial clock pulses with data high while latched
    task automatic latch(input int extra);
        cfg_latch = 1'b1;
        wait_clk(4);
        for (int k = 0; k < extra; k++) begin
            cfg_sdat = 1'b1;
            wait_clk(3); cfg_sclk = 1'b1;
            wait_clk(3); cfg_sclk = 1'b0;
        end
        wait_clk(4);
        cfg_latch = 1'b0;
        cfg_sdat = 1'b0;
        wait_clk(6);
    endtask

    initial begin
        model_defaults();
        wait_clk(5);
        check("R7 reset state during reset");
        rst_n = 1'b1;
        wait_clk(5);
        check("R7 reset state after release");

        // table walk: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            send_bits(VEC[v], 32);
            latch(0);
            model_apply(VEC[v]);
            check($sformatf("R%0d vector %0d", VREQ[v], v));
        end

        // R8: pulses while latched must not enter the word.
        // Short 30-bit word keeps the old low bits 00 in bits 31:30;
        // shifted ones there would turn it into a soft reset.
        send_bits(32'h0001_0334, 32);
        latch(2);
        model_apply(32'h0001_0334);
        check("R8 first word");
        send_bits(32'h0005_4490, 30);
        latch(0);
        model_apply(32'h0005_4490);
        check("R8 short word after latched pulses");

        // R1: a word followed by a longer stream keeps only the last 32 bits
        send_bits(32'hFFFF_FFFF, 16);
        send_bits(32'h0004_2A12, 32);
        latch(0);
        model_apply(32'h0004_2A12);
        check("R1 last 32 bits count");

        // R7: asynchronous reset mid-run restores defaults
        rst_n = 1'b0;
        wait_clk(1);
        model_defaults();
        check("R7 asynchronous reset");
        rst_n = 1'b1;
        wait_clk(4);
        check("R7 defaults held after release");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule